// File: doc/BRIEF.md
# Fault-Vectoring Priority Interrupt Controller

This block sits beside a small CPU core and turns internal events into distinct interrupt vectors. The lowest sixteen vectors belong to the core itself. Vector 0 is the periodic timer. Vectors 1 to 15 each belong to one dedicated fault wire from a separate circuit. Because every fault has its own vector, a handler learns which failure happened instead of seeing one merged fault line. Any of these sixteen vectors can also be raised by a software-interrupt instruction. External interrupt lines take vectors 16 and up.

A rising edge on any source sets a pending bit. The controller picks the pending vector with the lowest number and offers it to the CPU as a request strobe plus an 8-bit vector. It holds that offer until the CPU acknowledges, then clears that vector's pending bit and offers the next one. A global enable input gates the request without discarding pending work.

Top module: `fault_vec_intc`

## Requirements
- R1: After reset, and while reset is held, `irq_req` is 0 and `irq_vector` is 0, and no vector is pending.
- R2: A rising edge on `timer_tick` maps to vector 0, on `fault_lines[i]` to vector i+1, and on `ext_irq[j]` to vector 16+j. An edge sampled at clock edge k shows up on `irq_req`/`irq_vector` after clock edge k+1.
- R3: When several vectors are pending, the lowest-numbered one is presented. The timer beats every fault, and every internal source beats every external line.
- R4: Pending bits are set by rising edges only. A source held high raises its vector once and does not raise it again after acknowledge until it falls and rises again.
- R5: `swi_valid` high with `swi_num` = n (0 to 15) for one cycle makes vector n pending, exactly as the matching hardware source would.
- R6: While `irq_req` is high and no acknowledge arrives, `irq_vector` stays constant, even if a higher-priority vector becomes pending.
- R7: `irq_ack` high while `irq_req` is high clears the presented vector's pending bit. `irq_req` is 0 after that clock edge, and the next pending vector is presented one edge later.
- R8: `irq_ack` while `irq_req` is low has no effect on any pending bit.
- R9: `global_en` low forces `irq_req` to 0 but keeps all pending bits. When it returns high, the best pending vector is presented.
- R10: If a new edge of the vector being acknowledged arrives in the same cycle as the acknowledge, that vector stays pending and is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_tick | input | 1 | Timer event source, vector 0 |
| fault_lines | input | 15 | Fault sources; bit i raises vector i+1 |
| ext_irq | input | N_EXT | External sources; bit j raises vector 16+j |
| swi_valid | input | 1 | Software interrupt strobe |
| swi_num | input | 4 | Internal vector raised by the software interrupt |
| global_en | input | 1 | Global interrupt enable for the request output |
| irq_ack | input | 1 | One-cycle acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | VW | Vector currently offered |

## Verification
A corrupted pending bit shows up at the ports as a vector that is never offered or one that is offered twice. This becomes visible within two edges of the next acknowledge, or of re-enabling. A wrong priority decision shows up as the wrong vector on the first offer after simultaneous edges. A failure to hold the selection shows up as `irq_vector` changing while `irq_req` stays high. The vector table drives concurrent sources, acknowledges, masking and software injection, and checks both outputs after every edge. This catches each of these faults within one or two cycles of its cause.

// File: rtl/fault_vec_intc.sv
module fault_vec_intc #(
  parameter int N_EXT = 8,
  parameter int VW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timer_tick,
  input  logic [14:0]      fault_lines,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             swi_valid,
  input  logic [3:0]       swi_num,
  input  logic             global_en,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VW-1:0]    irq_vector
);
  localparam int NV = 16 + N_EXT;
  localparam int IW = $clog2(NV);

  logic [NV-1:0] raw, raw_q, pend, pend_d, rise, swi_hot, clr;
  logic [IW-1:0] cur_vec, best;
  logic          cur_valid, take;

  assign raw     = {ext_irq, fault_lines, timer_tick};
  assign rise    = raw & ~raw_q;
  assign swi_hot = swi_valid ? (NV'(1) << swi_num) : '0;
  assign irq_req = cur_valid & global_en;
  assign take    = irq_ack & irq_req;
  assign clr     = take ? (NV'(1) << cur_vec) : '0;
  assign pend_d  = (pend & ~clr) | rise | swi_hot;

  always_comb begin
    best = '0;
    for (int i = NV - 1; i >= 0; i--)
      if (pend[i]) best = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= '0;
      pend      <= '0;
      cur_vec   <= '0;
      cur_valid <= 1'b0;
    end else begin
      raw_q <= raw;
      pend  <= pend_d;
      if (take) begin
        cur_valid <= 1'b0;
      end else if (!irq_req) begin
        cur_valid <= |pend;
        cur_vec   <= best;
      end
    end
  end

  assign irq_vector = VW'(cur_vec);

  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (!irq_req || $stable(irq_vector))); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !rise[cur_vec] && !(swi_valid && IW'(swi_num) == cur_vec))
    |=> !pend[$past(cur_vec)]); // R7
  AST_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cur_vec < IW'(NV) && pend[cur_vec])); // R7
  AST_TIMER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_tick) |=> pend[0]); // R2
  AST_IGNORED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req) |=> (($past(pend) & ~pend) == '0)); // R8
  AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !global_en |=> (($past(pend) & ~pend) == '0)); // R9
endmodule

// File: tb/sim_fault_vec_intc.sv
module sim_fault_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        timer_tick = 1'b0;
  logic [14:0] fault_lines = '0;
  logic [7:0]  ext_irq = '0;
  logic        swi_valid = 1'b0;
  logic [3:0]  swi_num = '0;
  logic        global_en = 1'b1;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fault_vec_intc #(.N_EXT(8), .VW(8)) u0 (
    .clk, .rst_n, .timer_tick, .fault_lines, .ext_irq, .swi_valid,
    .swi_num, .global_en, .irq_ack, .irq_req, .irq_vector
  );

  // {req, timer, faults, ext, swi_v, swi_n, en, ack, exp_req, exp_vec}
  localparam int NROW = 31;
  localparam logic [43:0] TBL [NROW] = '{
    {4'd1,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R1 idle
    {4'd2,  1'b1, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R2 timer edge
    {4'd2,  1'b1, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd0},  // R2 vector 0
    {4'd7,  1'b1, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd0},  // R7 ack
    {4'd4,  1'b1, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R4 level held
    {4'd4,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R4 fall
    {4'd3,  1'b0, 15'h0012, 8'h01, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R3 vec 2,5,16
    {4'd3,  1'b0, 15'h0012, 8'h01, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd2},  // R3 lowest
    {4'd7,  1'b0, 15'h0012, 8'h01, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd2},  // R7
    {4'd3,  1'b0, 15'h0012, 8'h01, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd5},  // R3 next
    {4'd6,  1'b1, 15'h0012, 8'h01, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd5},  // R6 timer arrives
    {4'd6,  1'b1, 15'h0012, 8'h01, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd5},  // R6 held
    {4'd7,  1'b1, 15'h0012, 8'h01, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd5},  // R7
    {4'd3,  1'b1, 15'h0012, 8'h01, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd0},  // R3 timer over ext
    {4'd7,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd0},  // R7
    {4'd2,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd16}, // R2 ext vector
    {4'd7,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd16}, // R7
    {4'd7,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R7 empty
    {4'd5,  1'b0, 15'h0000, 8'h00, 1'b1, 4'd9, 1'b1, 1'b0, 1'b0, 8'd0},  // R5 swi 9
    {4'd5,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd9},  // R5
    {4'd9,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 8'd9},  // R9 masked
    {4'd8,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 8'd9},  // R8 ack ignored
    {4'd9,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd9},  // R9 reenabled
    {4'd7,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd9},  // R7
    {4'd7,  1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R7 empty
    {4'd10, 1'b0, 15'h0004, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0},  // R10 vec 3
    {4'd10, 1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd3},  // R10
    {4'd10, 1'b0, 15'h0004, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd3},  // R10 edge+ack
    {4'd10, 1'b0, 15'h0004, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 8'd3},  // R10 again
    {4'd10, 1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 8'd3},  // R10 ack
    {4'd10, 1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 8'd0}   // R10 cleared
  };

  task automatic chk(input int req, input logic exp_req, input logic [7:0] exp_vec);
    checks++;
    if (irq_req !== exp_req || irq_vector !== exp_vec) begin
      fails++;
      $display("FAIL R%0d: req=%b vec=%0d, expected req=%b vec=%0d",
               req, irq_req, irq_vector, exp_req, exp_vec);
    end
  endtask

  task automatic drive(input logic t, input logic [14:0] f, input logic [7:0] x,
                       input logic sv, input logic [3:0] sn, input logic en, input logic ak);
    timer_tick = t; fault_lines = f; ext_irq = x;
    swi_valid = sv; swi_num = sn; global_en = en; irq_ack = ak;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1, 1'b0, 8'd0); // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i][39], TBL[i][38:24], TBL[i][23:16], TBL[i][15], TBL[i][14:11],
            TBL[i][10], TBL[i][9]);
      @(negedge clk);
      chk(int'(TBL[i][43:40]), TBL[i][8], TBL[i][7:0]);
    end
    // R3 boundary: highest fault vs highest external
    drive(1'b0, 15'h4000, 8'h80, 1'b0, 4'd0, 1'b1, 1'b0);
    @(negedge clk); chk(3, 1'b0, 8'd0);
    @(negedge clk); chk(3, 1'b1, 8'd15);
    drive(1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1);
    @(negedge clk); chk(7, 1'b0, 8'd15);
    drive(1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0);
    @(negedge clk); chk(3, 1'b1, 8'd23);
    drive(1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b1);
    @(negedge clk); chk(7, 1'b0, 8'd23);
    // R5 software vector 0
    drive(1'b0, 15'h0000, 8'h00, 1'b1, 4'd0, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 15'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 1'b0);
    @(negedge clk); chk(5, 1'b1, 8'd0);
    // R1 reset while pending
    rst_n = 1'b0;
    @(negedge clk); chk(1, 1'b0, 8'd0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk); chk(1, 1'b0, 8'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule